// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Status

This block sits between a serial receiver and the CPU read port of a UART channel. Each time the receiver finishes a character, it hands over the data byte and three error flags: parity, framing and break. The queue keeps the byte and its flags together in a small first-in first-out store. The CPU pops entries one at a time, and each entry's error flags leave together with its data.

A one-entry holding stage sits beside the store. A character that completes while the store is full waits there and moves in as soon as a slot frees, so the block holds four characters in total. If the receiver reports the start of yet another character while a character is still waiting, the waiting character is discarded and a sticky overrun flag is raised. The error status shown to the CPU follows one of two rules, chosen by an input. In per-character mode it shows the flags of the oldest entry. In block mode it shows the OR of the flags of every entry that has become oldest since the last error-clear command.

Top module: `rx_status_fifo`

## Requirements
- R1: The store holds up to DEPTH (default 3) characters. Writes go into the next free slot, and `rd_data` always shows the oldest stored byte (0 when the store is empty).
- R2: `rx_rdy` is 1 exactly when at least one character is stored. `fifo_full` is 1 exactly when DEPTH characters are stored.
- R3: Each entry keeps its own error flags, which appear as `stat_perr`, `stat_ferr` and `stat_brk`. Overrun is not kept per entry.
- R4: With `block_mode`=0, the status outputs equal the flags of the oldest entry, and all three are 0 when the store is empty.
- R5: With `block_mode`=1, the status outputs are the OR of the flags of every entry that became oldest after the last `clr_err` pulse. A `clr_err` pulse sets this accumulator to 0, and the entry that is oldest at the time of the pulse is not added back.
- R6: Only `rd_pop` removes an entry, and it removes the oldest one. A `rd_pop` while the store is empty is ignored: it changes nothing.
- R7: A character that arrives while the store is full is held. It enters the store in the same cycle that a pop frees a slot, and it keeps its place after the stored characters.
- R8: An `rx_start` pulse while a character is held, with no pop in that cycle, discards the held character and sets `overrun`. The stored entries are unchanged.
- R9: `overrun` stays 1 until a `clr_err` pulse clears it. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R10: When a push and a pop coincide while the store is full, no character is lost and `overrun` is not raised. This also holds for `rx_start` together with a pop while a character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Receiver delivers a finished character this cycle |
| wr_data | input | DATA_W | Received character |
| wr_perr | input | 1 | Parity error flag of the delivered character |
| wr_ferr | input | 1 | Framing error flag of the delivered character |
| wr_brk | input | 1 | Break flag of the delivered character |
| rx_start | input | 1 | Receiver has detected the start bit of a new character |
| rd_pop | input | 1 | CPU data read: remove the oldest entry |
| block_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| clr_err | input | 1 | Error-clear command: clears the accumulator and overrun |
| rd_data | output | DATA_W | Oldest stored character |
| stat_perr | output | 1 | Parity error status |
| stat_ferr | output | 1 | Framing error status |
| stat_brk | output | 1 | Break status |
| rx_rdy | output | 1 | At least one character is stored |
| fifo_full | output | 1 | The store is full |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: DATA_W=8 and DEPTH=3. With these values the full store, the holding stage and the overrun are each reached in three to five pushes. Each error flag is given its own character, so a flag that lands in the wrong place, or travels with the wrong byte, shows up at the status outputs. A shallow depth also keeps the pointer wrap-around within a short test, which exercises the coincident push-and-pop cases at the non-power-of-two boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_stat_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 3,
  parameter int W      = 11,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_word,
  input  logic              rd_en,
  output logic [W-1:0]      head_word,
  output logic [STAT_W-1:0] next_stat,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_word = mem[rd_ptr];
  assign next_stat = mem[bump(rd_ptr)][STAT_W-1:0];

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count != CNT_W'(DEPTH)) || rd_en);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         take,
  input  logic         drop,
  output logic         valid,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      word  <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        word  <= load_word;
      end else if (take || drop) begin
        valid <= 1'b0;
      end
    end
  end

  p_take_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (take || drop) |-> valid);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     block_mode,
  input  logic     clr,
  input  logic     arrive,
  input  rx_stat_t arrive_stat,
  input  logic     head_valid,
  input  rx_stat_t head_stat,
  input  logic     ovr_set,
  output rx_stat_t stat_out,
  output logic     overrun
);
  rx_stat_t acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      overrun <= 1'b0;
    end else begin
      acc <= (clr ? rx_stat_t'('0) : acc) | (arrive ? arrive_stat : rx_stat_t'('0));
      if (ovr_set)  overrun <= 1'b1;
      else if (clr) overrun <= 1'b0;
    end
  end

  always_comb begin
    if (block_mode)      stat_out = acc;
    else if (head_valid) stat_out = head_stat;
    else                 stat_out = '0;
  end

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clr) |=> overrun);
  p_overrun_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !ovr_set) |=> !overrun);
  p_acc_monotone_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !arrive) |=> $stable(acc));
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              wr_brk,
  input  logic              rx_start,
  input  logic              rd_pop,
  input  logic              block_mode,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              stat_perr,
  output logic              stat_ferr,
  output logic              stat_brk,
  output logic              rx_rdy,
  output logic              fifo_full,
  output logic              overrun
);
  localparam int W     = DATA_W + STAT_W;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0]  count;
  logic [W-1:0]      head_word, push_word, hold_word, wr_word;
  logic [STAT_W-1:0] next_stat;
  logic              hold_valid, pop_ok, room, wr_en;
  logic              hold_take, hold_load, hold_drop, ovr_set;
  logic              arrive, arrive_from_pop;
  rx_stat_t          arrive_stat, head_stat, stat_out;

  assign push_word = {wr_data, wr_brk, wr_ferr, wr_perr};
  assign rx_rdy    = (count != '0);
  assign fifo_full = (count == CNT_W'(DEPTH));
  assign pop_ok    = rd_pop && rx_rdy;
  assign room      = !fifo_full || pop_ok;

  // held character has priority over a fresh one for the free slot
  assign wr_word   = hold_valid ? hold_word : push_word;
  assign wr_en     = room && (hold_valid || wr_valid);
  assign hold_take = hold_valid && room;
  assign hold_load = wr_valid && (hold_valid || !room);
  assign hold_drop = rx_start && hold_valid && !hold_take;
  assign ovr_set   = hold_drop || (wr_valid && hold_valid && !hold_take);

  // which entry becomes oldest this cycle
  assign arrive_from_pop = pop_ok && (count >= CNT_W'(2));
  assign arrive = arrive_from_pop ||
                  (wr_en && ((count == '0) || ((count == CNT_W'(1)) && pop_ok)));
  assign arrive_stat = arrive_from_pop ? rx_stat_t'(next_stat)
                                       : rx_stat_t'(wr_word[STAT_W-1:0]);
  assign head_stat = rx_stat_t'(head_word[STAT_W-1:0]);

  rxq_store #(.DEPTH(DEPTH), .W(W), .STAT_W(STAT_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .rd_en     (pop_ok),
    .head_word (head_word),
    .next_stat (next_stat),
    .count     (count)
  );

  rxq_hold #(.W(W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (hold_load),
    .load_word (push_word),
    .take      (hold_take),
    .drop      (hold_drop),
    .valid     (hold_valid),
    .word      (hold_word)
  );

  rxq_status u_status (
    .clk         (clk),
    .rst         (rst),
    .block_mode  (block_mode),
    .clr         (clr_err),
    .arrive      (arrive),
    .arrive_stat (arrive_stat),
    .head_valid  (rx_rdy),
    .head_stat   (head_stat),
    .ovr_set     (ovr_set),
    .stat_out    (stat_out),
    .overrun     (overrun)
  );

  assign rd_data   = rx_rdy ? head_word[W-1:STAT_W] : '0;
  assign stat_perr = stat_out.perr;
  assign stat_ferr = stat_out.ferr;
  assign stat_brk  = stat_out.brk;

  p_hold_only_full_r7: assert property (@(posedge clk) disable iff (rst)
    hold_valid |-> fifo_full);
  p_full_implies_rdy_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rx_rdy);
  p_no_loss_on_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && fifo_full && !clr_err) |=> $stable(overrun));
  p_hold_keeps_full_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !rd_pop) |=> fifo_full);
endmodule

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_valid, wr_perr, wr_ferr, wr_brk;
  logic [7:0] wr_data;
  logic       rx_start, rd_pop, block_mode, clr_err;
  logic [7:0] rd_data;
  logic       stat_perr, stat_ferr, stat_brk, rx_rdy, fifo_full, overrun;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  rx_status_fifo #(.DATA_W(8), .DEPTH(3)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rx_start(rx_start), .rd_pop(rd_pop), .block_mode(block_mode),
    .clr_err(clr_err), .rd_data(rd_data), .stat_perr(stat_perr),
    .stat_ferr(stat_ferr), .stat_brk(stat_brk), .rx_rdy(rx_rdy),
    .fifo_full(fifo_full), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status packed as {brk,ferr,perr}
  function automatic int stv();
    return {29'd0, stat_brk, stat_ferr, stat_perr};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rd_pop = 0; rx_start = 0; clr_err = 0;
  endtask

  task automatic cyc(input logic push, input logic [7:0] d, input logic [2:0] s,
                     input logic pop, input logic st, input logic clr);
    wr_valid = push; wr_data = d; {wr_brk, wr_ferr, wr_perr} = s;
    rd_pop = pop; rx_start = st; clr_err = clr;
    step();
  endtask

  task automatic do_reset();
    rst = 1; wr_valid = 0; rd_pop = 0; rx_start = 0; clr_err = 0;
    block_mode = 0; wr_data = 0; wr_perr = 0; wr_ferr = 0; wr_brk = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 rx_rdy after reset", rx_rdy, 0);
    chk("R2 fifo_full after reset", fifo_full, 0);
    chk("R9 overrun after reset", overrun, 0);
    chk("R4 status after reset", stv(), 0);
  endtask

  task automatic t_order();
    do_reset();
    cyc(1, 8'hA1, 3'b001, 0, 0, 0);
    chk("R2 rdy one entry", rx_rdy, 1);
    chk("R2 not full one entry", fifo_full, 0);
    cyc(1, 8'hA2, 3'b010, 0, 0, 0);
    cyc(1, 8'hA3, 3'b100, 0, 0, 0);
    chk("R2 full three entries", fifo_full, 1);
    chk("R1 head oldest", rd_data, 8'hA1);
    chk("R4 head status", stv(), 3'b001);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R1 second", rd_data, 8'hA2);
    chk("R3 status with second", stv(), 3'b010);
    chk("R2 not full after pop", fifo_full, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R1 third", rd_data, 8'hA3);
    chk("R3 status with third", stv(), 3'b100);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R2 empty", rx_rdy, 0);
    chk("R4 empty status zero", stv(), 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 pop on empty ignored", rx_rdy, 0);
    cyc(1, 8'h5C, 3'b000, 0, 0, 0);
    chk("R6 push after empty pop", rd_data, 8'h5C);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 empty again", rx_rdy, 0);
  endtask

  task automatic t_block();
    do_reset();
    block_mode = 1;
    cyc(1, 8'h11, 3'b001, 0, 0, 0);
    cyc(1, 8'h12, 3'b100, 0, 0, 0);
    chk("R5 only head counted", stv(), 3'b001);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 second reaches head", stv(), 3'b101);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R5 clear zeroes", stv(), 0);
    chk("R6 clear keeps data", rd_data, 8'h12);
    cyc(1, 8'h13, 3'b010, 0, 0, 0);
    chk("R5 non-head not counted", stv(), 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 new head counted", stv(), 3'b010);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 kept when empty", stv(), 3'b010);
    block_mode = 0;
    @(negedge clk);
    chk("R4 char mode empty", stv(), 0);
  endtask

  task automatic t_hold();
    do_reset();
    cyc(1, 8'h21, 3'b000, 0, 0, 0);
    cyc(1, 8'h22, 3'b000, 0, 0, 0);
    cyc(1, 8'h23, 3'b000, 0, 0, 0);
    cyc(1, 8'h24, 3'b110, 0, 0, 0);
    chk("R7 head unchanged with held", rd_data, 8'h21);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 still full after move-in", fifo_full, 1);
    chk("R7 second", rd_data, 8'h22);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 held char last", rd_data, 8'h24);
    chk("R7 held status travels", stv(), 3'b110);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 drained", rx_rdy, 0);
    chk("R9 no overrun", overrun, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    cyc(1, 8'h31, 3'b000, 0, 0, 0);
    cyc(1, 8'h32, 3'b000, 0, 0, 0);
    cyc(1, 8'h33, 3'b000, 0, 0, 0);
    cyc(1, 8'h34, 3'b000, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 overrun set", overrun, 1);
    chk("R8 head unchanged", rd_data, 8'h31);
    cyc(1, 8'h35, 3'b001, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 second", rd_data, 8'h32);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 discarded char skipped", rd_data, 8'h35);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 empty", rx_rdy, 0);
    chk("R9 sticky", overrun, 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R9 cleared", overrun, 0);
  endtask

  task automatic t_simul();
    do_reset();
    cyc(1, 8'h41, 3'b000, 0, 0, 0);
    cyc(1, 8'h42, 3'b000, 0, 0, 0);
    cyc(1, 8'h43, 3'b000, 0, 0, 0);
    cyc(1, 8'h44, 3'b000, 0, 0, 0);
    cyc(1, 8'h45, 3'b000, 1, 0, 0);
    chk("R10 push+pop head", rd_data, 8'h42);
    chk("R10 full", fifo_full, 1);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R10 start with pop no overrun", overrun, 0);
    chk("R10 head", rd_data, 8'h43);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 fourth kept", rd_data, 8'h44);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 fifth kept", rd_data, 8'h45);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 empty", rx_rdy, 0);
    cyc(1, 8'h51, 3'b000, 0, 0, 0);
    cyc(1, 8'h52, 3'b000, 0, 0, 0);
    cyc(1, 8'h53, 3'b000, 0, 0, 0);
    cyc(1, 8'h54, 3'b000, 1, 0, 0);
    chk("R10 direct entry head", rd_data, 8'h52);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 direct entry tail", rd_data, 8'h54);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10 drained", rx_rdy, 0);
    chk("R9 still no overrun", overrun, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_block();
    t_hold();
    t_overrun();
    t_simul();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule